// File: doc/BRIEF.md
# Sixteen-Operation Word ALU

This block is the combinational arithmetic logic unit of a small processor whose memory is addressed by 16-bit word, with no byte addressing. A 4-bit operation code picks one of sixteen operations on two 16-bit operands, `opA` and `opB`. The sixteen operations are a pass-through, three bitwise logic functions, negation, single-bit shifts, three byte-shuffling operations, addition with and without carry, subtraction, and an unsigned multiply that returns either half of the product. The last code is kept back and flagged as illegal.

The result appears in the same cycle, together with a carry output and zero and negative flags. The byte operations exist because software cannot address bytes, so it needs cheap ways to reorder and mask the two halves of a word. Both multiply forms share one 16x16 product, which fits inside a hard 18x18 multiplier element. Division and floating point are not provided.

Inside, a control decoder turns the opcode into a small packed struct of strobes, and the datapath uses those strobes to steer its adder, logic unit, shifter, byte unit and multiplier into the result.

Top module: `word_alu`

## Requirements
- R1: Code 0 (copy) drives `result` equal to `opA`; `opB` has no effect on the result.
- R2: Codes 1, 2 and 3 produce `opA & opB`, `opA | opB` and `opA ^ opB` respectively.
- R3: Code 4 produces the two's-complement negation of `opA` (0 - opA modulo 2^16).
- R4: Code 5 shifts `opA` left by one bit and code 6 shifts it right by one bit, both filling the vacated bit with 0.
- R5: Code 7 exchanges bits 15:8 and 7:0 of `opA`; code 8 clears bits 7:0 of `opA`; code 9 clears bits 15:8 of `opA`.
- R6: Code 10 gives `opA + opB` and code 11 gives `opA + opB + carryIn`, each modulo 2^16, with `carryOut` set to the carry out of bit 15.
- R7: Code 12 gives `opA - opB` modulo 2^16, with `carryOut` = 1 exactly when no borrow occurs (opA >= opB unsigned).
- R8: Code 13 gives bits 15:0 and code 14 gives bits 31:16 of the unsigned 32-bit product `opA * opB`.
- R9: `carryOut` is 0 for every code other than 10, 11 and 12, and `carryIn` affects the outputs only under code 11.
- R10: For codes 0 to 14, `zeroFlag` is 1 exactly when `result` is 0, and `negFlag` equals bit 15 of `result`.
- R11: Code 15 gives `result` = 0, `carryOut` = 0, `zeroFlag` = 0, `negFlag` = 0 and `illegalOp` = 1; every other code gives `illegalOp` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First operand, also the only operand of the one-input operations |
| opB | input | 16 | Second operand |
| opCode | input | 4 | Operation select, encoded as in R1 to R11 |
| carryIn | input | 1 | Carry input, used only by add-with-carry |
| result | output | 16 | Operation result |
| carryOut | output | 1 | Carry or no-borrow from the add and subtract operations |
| zeroFlag | output | 1 | Result is zero |
| negFlag | output | 1 | Most significant bit of the result |
| illegalOp | output | 1 | Reserved opcode was presented |

## Verification
On every evaluation, the assertions check the relations that can be seen from the ports and the strobe struct alone. They check that the reserved code zeroes every output and raises the illegal flag, that carry stays low outside the three add and subtract codes, that copy passes `opA`, that the shifts fill with zero, and that the subtract carry matches an unsigned comparison of the operands. The value of each arithmetic, byte and logic result, the high half of the product, and the fact that `opB` and `carryIn` are ignored where required can only be shown by the bench's scenarios. The bench compares every opcode against an independent model, using corner operands such as 0, 0xFFFF, 0x8000 and equal operands, and then a long run of random operands.

// File: rtl/word_alu_pkg.sv
package word_alu_pkg;

  typedef enum logic [3:0] {
    OP_COPY  = 4'd0,
    OP_AND   = 4'd1,
    OP_OR    = 4'd2,
    OP_XOR   = 4'd3,
    OP_NEG   = 4'd4,
    OP_SHL   = 4'd5,
    OP_SHR   = 4'd6,
    OP_SWAP  = 4'd7,
    OP_CLRLO = 4'd8,
    OP_CLRHI = 4'd9,
    OP_ADD   = 4'd10,
    OP_ADC   = 4'd11,
    OP_SUB   = 4'd12,
    OP_MULLO = 4'd13,
    OP_MULHI = 4'd14,
    OP_RSVD  = 4'd15
  } aluOp_e;

  typedef enum logic [2:0] {
    SEL_PASS  = 3'd0,
    SEL_LOGIC = 3'd1,
    SEL_SHIFT = 3'd2,
    SEL_BYTE  = 3'd3,
    SEL_SUM   = 3'd4,
    SEL_MUL   = 3'd5,
    SEL_ZERO  = 3'd6
  } resSel_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logicFn_e;

  typedef enum logic [1:0] {
    BY_SWAP  = 2'd0,
    BY_CLRLO = 2'd1,
    BY_CLRHI = 2'd2
  } byteFn_e;

  typedef enum logic [1:0] {
    CI_ZERO  = 2'd0,
    CI_ONE   = 2'd1,
    CI_INPUT = 2'd2
  } cinMode_e;

  // Strobes handed from the decoder to the datapath
  typedef struct packed {
    resSel_e  resSel;
    logicFn_e logicFn;
    logic     shiftLeft;
    byteFn_e  byteFn;
    logic     addXZero;   // adder X operand forced to zero
    logic     addYFromA;  // adder Y operand taken from A instead of B
    logic     addInvY;    // adder Y operand inverted
    cinMode_e cinMode;
    logic     carryEn;
    logic     mulHigh;
    logic     illegal;
  } aluCtl_t;

endpackage

// File: rtl/word_alu_ctrl.sv
module word_alu_ctrl
  import word_alu_pkg::*;
(
  input  logic [3:0] opCode,
  output aluCtl_t    ctl
);

  always_comb begin
    ctl           = '0;
    ctl.resSel    = SEL_PASS;
    ctl.logicFn   = LG_AND;
    ctl.byteFn    = BY_SWAP;
    ctl.cinMode   = CI_ZERO;
    unique case (aluOp_e'(opCode))
      OP_COPY:  ctl.resSel = SEL_PASS;
      OP_AND:   begin ctl.resSel = SEL_LOGIC; ctl.logicFn = LG_AND; end
      OP_OR:    begin ctl.resSel = SEL_LOGIC; ctl.logicFn = LG_OR;  end
      OP_XOR:   begin ctl.resSel = SEL_LOGIC; ctl.logicFn = LG_XOR; end
      OP_NEG: begin
        ctl.resSel    = SEL_SUM;
        ctl.addXZero  = 1'b1;
        ctl.addYFromA = 1'b1;
        ctl.addInvY   = 1'b1;
        ctl.cinMode   = CI_ONE;
      end
      OP_SHL:   begin ctl.resSel = SEL_SHIFT; ctl.shiftLeft = 1'b1; end
      OP_SHR:   begin ctl.resSel = SEL_SHIFT; ctl.shiftLeft = 1'b0; end
      OP_SWAP:  begin ctl.resSel = SEL_BYTE; ctl.byteFn = BY_SWAP;  end
      OP_CLRLO: begin ctl.resSel = SEL_BYTE; ctl.byteFn = BY_CLRLO; end
      OP_CLRHI: begin ctl.resSel = SEL_BYTE; ctl.byteFn = BY_CLRHI; end
      OP_ADD: begin
        ctl.resSel  = SEL_SUM;
        ctl.carryEn = 1'b1;
      end
      OP_ADC: begin
        ctl.resSel  = SEL_SUM;
        ctl.cinMode = CI_INPUT;
        ctl.carryEn = 1'b1;
      end
      OP_SUB: begin
        ctl.resSel  = SEL_SUM;
        ctl.addInvY = 1'b1;
        ctl.cinMode = CI_ONE;
        ctl.carryEn = 1'b1;
      end
      OP_MULLO: ctl.resSel = SEL_MUL;
      OP_MULHI: begin ctl.resSel = SEL_MUL; ctl.mulHigh = 1'b1; end
      OP_RSVD: begin
        ctl.resSel  = SEL_ZERO;
        ctl.illegal = 1'b1;
      end
      default: ctl.resSel = SEL_ZERO;
    endcase
  end

  // R11: only the reserved code raises the illegal strobe
  always_comb begin
    a_r11_illegal_decode: assert (ctl.illegal == (opCode == 4'd15))
      else $error("R11 illegal strobe does not match reserved code");
  end

endmodule

// File: rtl/word_alu_dp.sv
module word_alu_dp
  import word_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  aluCtl_t          ctl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             zeroFlag,
  output logic             negFlag
);

  localparam int HALF = WIDTH / 2;
  localparam int PROD = 2 * WIDTH;

  logic [WIDTH-1:0] logicRes;
  logic [WIDTH-1:0] shiftRes;
  logic [WIDTH-1:0] byteRes;
  logic [WIDTH-1:0] addX;
  logic [WIDTH-1:0] addY;
  logic             addCin;
  logic [WIDTH:0]   sumFull;
  logic [PROD-1:0]  product;
  logic [WIDTH-1:0] mulRes;

  // Bitwise logic unit
  always_comb begin
    unique case (ctl.logicFn)
      LG_AND:  logicRes = opA & opB;
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      default: logicRes = '0;
    endcase
  end

  // One-bit shifter, zero fill
  assign shiftRes = ctl.shiftLeft ? {opA[WIDTH-2:0], 1'b0}
                                  : {1'b0, opA[WIDTH-1:1]};

  // Byte unit
  always_comb begin
    unique case (ctl.byteFn)
      BY_SWAP:  byteRes = {opA[HALF-1:0], opA[WIDTH-1:HALF]};
      BY_CLRLO: byteRes = {opA[WIDTH-1:HALF], {HALF{1'b0}}};
      BY_CLRHI: byteRes = {{(WIDTH-HALF){1'b0}}, opA[HALF-1:0]};
      default:  byteRes = '0;
    endcase
  end

  // Shared adder: add, add-with-carry, subtract and negate
  always_comb begin
    addX = ctl.addXZero ? '0 : opA;
    addY = ctl.addYFromA ? opA : opB;
    if (ctl.addInvY) addY = ~addY;
    unique case (ctl.cinMode)
      CI_ZERO:  addCin = 1'b0;
      CI_ONE:   addCin = 1'b1;
      CI_INPUT: addCin = carryIn;
      default:  addCin = 1'b0;
    endcase
  end

  assign sumFull = {1'b0, addX} + {1'b0, addY} + {{WIDTH{1'b0}}, addCin};

  // One unsigned product feeds both multiply forms
  assign product = {{WIDTH{1'b0}}, opA} * {{WIDTH{1'b0}}, opB};
  assign mulRes  = ctl.mulHigh ? product[PROD-1:WIDTH] : product[WIDTH-1:0];

  // Result steering
  always_comb begin
    unique case (ctl.resSel)
      SEL_PASS:  result = opA;
      SEL_LOGIC: result = logicRes;
      SEL_SHIFT: result = shiftRes;
      SEL_BYTE:  result = byteRes;
      SEL_SUM:   result = sumFull[WIDTH-1:0];
      SEL_MUL:   result = mulRes;
      default:   result = '0;
    endcase
  end

  assign carryOut = ctl.carryEn & sumFull[WIDTH];
  assign zeroFlag = ~ctl.illegal & (result == '0);
  assign negFlag  = ~ctl.illegal & result[WIDTH-1];

  // R4: the vacated bit of a shift is always zero
  always_comb begin
    if (ctl.resSel == SEL_SHIFT && ctl.shiftLeft)
      a_r4_shl_fill: assert (result[0] == 1'b0)
        else $error("R4 left shift did not fill bit 0 with zero");
    if (ctl.resSel == SEL_SHIFT && !ctl.shiftLeft)
      a_r4_shr_fill: assert (result[WIDTH-1] == 1'b0)
        else $error("R4 right shift did not fill top bit with zero");
  end

endmodule

// File: rtl/word_alu.sv
module word_alu
  import word_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       opCode,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             zeroFlag,
  output logic             negFlag,
  output logic             illegalOp
);

  aluCtl_t ctl;

  word_alu_ctrl u_ctrl (
    .opCode (opCode),
    .ctl    (ctl)
  );

  word_alu_dp #(.WIDTH(WIDTH)) u_dp (
    .ctl      (ctl),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .result   (result),
    .carryOut (carryOut),
    .zeroFlag (zeroFlag),
    .negFlag  (negFlag)
  );

  assign illegalOp = ctl.illegal;

  // Port-level relations between decoder and datapath
  always_comb begin
    if (opCode == 4'd15)
      a_r11_reserved_quiet: assert (result == '0 && !carryOut && !zeroFlag
                                    && !negFlag && illegalOp)
        else $error("R11 reserved code did not clear outputs");
    if (opCode != 4'd10 && opCode != 4'd11 && opCode != 4'd12)
      a_r9_carry_clear: assert (!carryOut)
        else $error("R9 carry set outside add/subtract");
    if (opCode == 4'd0)
      a_r1_copy_pass: assert (result == opA)
        else $error("R1 copy did not pass operand A");
    if (opCode == 4'd12)
      a_r7_no_borrow: assert (carryOut == (opA >= opB))
        else $error("R7 subtract carry disagrees with comparison");
  end

endmodule

// File: tb/word_alu_tb.sv
module word_alu_tb;

  localparam int W = 16;

  typedef struct {
    logic [3:0]   op;
    logic [W-1:0] res;
    logic         c;
    logic         z;
    logic         n;
    logic         ill;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [3:0]   opCode = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] result;
  logic         carryOut, zeroFlag, negFlag, illegalOp;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  exp_t sbq[$];

  always #2.5 clk = ~clk;

  word_alu #(.WIDTH(W)) u_dut (
    .opA(opA), .opB(opB), .opCode(opCode), .carryIn(carryIn),
    .result(result), .carryOut(carryOut), .zeroFlag(zeroFlag),
    .negFlag(negFlag), .illegalOp(illegalOp)
  );

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1, 4'd2, 4'd3: return "R2";
      4'd4: return "R3";
      4'd5, 4'd6: return "R4";
      4'd7, 4'd8, 4'd9: return "R5";
      4'd10, 4'd11: return "R6";
      4'd12: return "R7";
      4'd13, 4'd14: return "R8";
      default: return "R11";
    endcase
  endfunction

  // Reference model written from the requirements
  function automatic exp_t model(input logic [3:0] op, input logic [W-1:0] a,
                                 input logic [W-1:0] b, input logic ci);
    exp_t e;
    logic [W:0]     s;
    logic [2*W-1:0] p;
    e.op = op; e.res = '0; e.c = 1'b0; e.ill = 1'b0;
    p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    case (op)
      4'd0:  e.res = a;
      4'd1:  e.res = a & b;
      4'd2:  e.res = a | b;
      4'd3:  e.res = a ^ b;
      4'd4:  e.res = W'(0) - a;
      4'd5:  e.res = a << 1;
      4'd6:  e.res = a >> 1;
      4'd7:  e.res = {a[7:0], a[15:8]};
      4'd8:  e.res = {a[15:8], 8'h00};
      4'd9:  e.res = {8'h00, a[7:0]};
      4'd10: begin s = {1'b0, a} + {1'b0, b}; e.res = s[W-1:0]; e.c = s[W]; end
      4'd11: begin s = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
                   e.res = s[W-1:0]; e.c = s[W]; end
      4'd12: begin e.res = a - b; e.c = (a >= b); end
      4'd13: e.res = p[W-1:0];
      4'd14: e.res = p[2*W-1:W];
      default: e.ill = 1'b1;
    endcase
    e.z = !e.ill && (e.res == '0);
    e.n = !e.ill && e.res[W-1];
    return e;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: apply one operation per cycle and queue its expectation
  task automatic drive(input logic [3:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic ci);
    @(posedge clk);
    opCode <= op; opA <= a; opB <= b; carryIn <= ci;
    sbq.push_back(model(op, a, b, ci));
  endtask

  // Monitor: compare the queued item half a cycle after it was applied
  always @(negedge clk) begin
    if (!rst && sbq.size() > 0) begin
      exp_t e;
      string rq;
      e = sbq.pop_front();
      rq = reqOf(e.op);
      check(rq, "result", result, e.res);
      check((e.op >= 4'd10 && e.op <= 4'd12) ? rq : "R9", "carry",
            {15'd0, carryOut}, {15'd0, e.c});
      check(e.ill ? "R11" : "R10", "zero", {15'd0, zeroFlag}, {15'd0, e.z});
      check(e.ill ? "R11" : "R10", "neg",  {15'd0, negFlag},  {15'd0, e.n});
      check("R11", "illegal", {15'd0, illegalOp}, {15'd0, e.ill});
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst <= 1'b0;
    @(negedge clk);
    // Idle state: copy of zero gives zero result and zero flag set
    check("R1", "idle result", result, 16'h0000);
    check("R10", "idle zero", {15'd0, zeroFlag}, 16'd1);
    check("R11", "idle illegal", {15'd0, illegalOp}, 16'd0);

    // R1: opB ignored by copy
    drive(4'd0, 16'h1234, 16'h0000, 1'b0);
    drive(4'd0, 16'h1234, 16'hFFFF, 1'b1);
    // R2
    drive(4'd1, 16'hF0F0, 16'h3C3C, 1'b0);
    drive(4'd2, 16'hF0F0, 16'h0F0F, 1'b0);
    drive(4'd3, 16'hAAAA, 16'hAAAA, 1'b0);
    // R3 corners
    drive(4'd4, 16'h0000, 16'h5555, 1'b0);
    drive(4'd4, 16'h8000, 16'h0000, 1'b0);
    drive(4'd4, 16'h0001, 16'h0000, 1'b1);
    // R4 corners
    drive(4'd5, 16'h8001, 16'h0000, 1'b1);
    drive(4'd6, 16'h8001, 16'h0000, 1'b1);
    drive(4'd5, 16'h8000, 16'h0000, 1'b0);
    // R5
    drive(4'd7, 16'hAB12, 16'h0000, 1'b0);
    drive(4'd8, 16'hAB12, 16'h0000, 1'b0);
    drive(4'd9, 16'hAB12, 16'h0000, 1'b0);
    drive(4'd9, 16'hFF00, 16'h0000, 1'b0);
    // R6 and R9: carryIn ignored by plain add, used by add-with-carry
    drive(4'd10, 16'hFFFF, 16'h0001, 1'b1);
    drive(4'd10, 16'h1000, 16'h0234, 1'b1);
    drive(4'd11, 16'hFFFF, 16'h0000, 1'b1);
    drive(4'd11, 16'hFFFE, 16'h0000, 1'b1);
    // R7: equal, smaller, larger
    drive(4'd12, 16'h4321, 16'h4321, 1'b0);
    drive(4'd12, 16'h0001, 16'h0002, 1'b0);
    drive(4'd12, 16'h8000, 16'h0001, 1'b1);
    // R8
    drive(4'd13, 16'hFFFF, 16'hFFFF, 1'b0);
    drive(4'd14, 16'hFFFF, 16'hFFFF, 1'b0);
    drive(4'd14, 16'h0100, 16'h0100, 1'b0);
    drive(4'd13, 16'h0100, 16'h0100, 1'b0);
    // R11 with operands that would otherwise set flags
    drive(4'd15, 16'hFFFF, 16'hFFFF, 1'b1);
    drive(4'd15, 16'h0000, 16'h0000, 1'b0);

    // Random sweep over every opcode, with carryIn toggled (R9, R10)
    for (int i = 0; i < 4000; i++) begin
      drive(4'(i % 16), W'($urandom), W'($urandom), 1'($urandom));
    end

    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule